// File: doc/BRIEF.md
# Periodic Rate Generator Timer

This block holds several independent 16-bit down-counting channels, all clocked by the same input clock and programmed over a narrow byte-wide write bus. Software first writes a control byte to the shared control address to arm a channel. It then writes the channel's 16-bit divisor to that channel's own data address as two bytes, least significant byte first. Once the second byte lands, the channel divides the clock by the divisor. It produces an output that is normally high and drops for exactly one clock once per period. Channel 0 is intended to be the source of the system tick interrupt.

Only the periodic divide-by-N behaviour with binary counts is implemented. Every channel runs a four-state machine:
- `CH_IDLE`: stopped, expecting the low byte.
- `CH_LOAD_HI`: stopped, holding the low byte and expecting the high byte.
- `CH_RUN`: counting, expecting a low byte.
- `CH_RUN_HI`: counting, holding a new low byte and expecting its high byte.

The transitions are:
- Any data write moves `CH_IDLE` to `CH_LOAD_HI`, `CH_LOAD_HI` to `CH_RUN`, `CH_RUN` to `CH_RUN_HI`, and `CH_RUN_HI` to `CH_RUN`.
- An accepted control byte for the channel sends any state back to `CH_IDLE`.

Top module: `pit_rate_gen`

## Requirements
- R1: After reset every channel is stopped and every `chan_out` bit is 1.
- R2: A write to address 3 is a control byte. It is accepted only when all of the following hold: bits 7:6 name a channel below NUM_CH, bits 5:4 are 11, bits 3:1 are 010 and bit 0 is 0. The values 0x34, 0x74 and 0xB4 select channels 0, 1 and 2.
- R3: A control byte whose bits 7:6 are 11, or whose access, mode or count-type field differs from R2, has no effect on any channel.
- R4: An accepted control byte stops its channel and forces its output high on the next clock. No pulse appears until a complete low-then-high count has been written.
- R5: Writes to address `k` (k < NUM_CH) are data bytes for channel `k`. After a control byte, the first data byte is the low byte and the second is the high byte. A low byte alone leaves the channel stopped.
- R6: With divisor N (N ≥ 2), the counter is loaded on the clock edge that takes the high byte. The first low pulse begins N-1 edges later.
- R7: While running, the output is low for exactly one clock and the spacing between low pulses is N clocks.
- R8: A divisor of 0 acts as 65536.
- R9: A low/high pair written while the channel runs does not disturb the current period. The new divisor is used from the next reload on, including a reload that falls on the same edge as the high byte.
- R10: Channels count independently. Writes aimed at one channel do not change the period or phase of another.
- R11: A divisor of 1 keeps the output low continuously while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per clock in which it is high |
| bus_addr | input | 2 | 0..NUM_CH-1 select a channel data port, 3 selects the control port |
| bus_wdata | input | 8 | Write byte |
| chan_out | output | NUM_CH | Per-channel output, high with a single-clock low pulse each period |

## Verification
The assertions assume one byte per clock on the bus and no writes to an unused channel address. They also assume that the state a divisor leaves behind is only observed through the counter. The single-low-clock property therefore excludes a divisor of 1 and excludes cycles in which a byte is being written. The stimulus always holds the strobe for exactly one edge and drives the bus on the falling edge. It writes only the addresses the requirements define. A behavioural model in the bench keeps, per channel, a running flag, a byte-order flag and a cycles-to-pulse counter, and is compared against `chan_out` on every clock.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 2 * BYTE_W;
    localparam int ADDR_W    = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'b11;
    localparam logic [1:0] SEL_NONE   = 2'b11;
    localparam logic [1:0] ACC_LO_HI  = 2'b11;
    localparam logic [2:0] MODE_RATE  = 3'b010;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_LOAD_HI,
        CH_RUN,
        CH_RUN_HI
    } ch_state_e;
endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [NUM_CH-1:0] ctrl_hit,
    output logic [NUM_CH-1:0] data_hit
);
    logic [1:0] sel;
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
    logic       ctrl_ok;

    assign sel  = bus_wdata[7:6];
    assign acc  = bus_wdata[5:4];
    assign mode = bus_wdata[3:1];
    assign bcd  = bus_wdata[0];

    assign ctrl_ok = bus_wr && (bus_addr == CTRL_ADDR) && (sel != SEL_NONE)
                     && (acc == ACC_LO_HI) && (mode == MODE_RATE) && !bcd;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign ctrl_hit[i] = ctrl_ok && (sel == 2'(i));
        assign data_hit[i] = bus_wr && (bus_addr == ADDR_W'(i));
    end

    // R2
    ctrl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_hit));

    // R3
    ctrl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_ADDR && bus_wdata[7:6] == SEL_NONE) |-> (ctrl_hit == '0));

    // R10
    data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(data_hit) <= 1 && (ctrl_hit & data_hit) == '0);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              tick_n
);
    ch_state_e         state_q, state_d;
    logic [BYTE_W-1:0] lo_q;
    logic [CNT_W-1:0]  reload_q, reload_d, cnt_q;
    logic              hi_done, counting;

    assign hi_done  = data_wr && (state_q == CH_LOAD_HI || state_q == CH_RUN_HI);
    assign counting = (state_q == CH_RUN || state_q == CH_RUN_HI);
    assign reload_d = hi_done ? {wdata, lo_q} : reload_q;

    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            state_d = CH_IDLE;
        end else if (data_wr) begin
            unique case (state_q)
                CH_IDLE:    state_d = CH_LOAD_HI;
                CH_LOAD_HI: state_d = CH_RUN;
                CH_RUN:     state_d = CH_RUN_HI;
                CH_RUN_HI:  state_d = CH_RUN;
                default:    state_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q     <= '0;
            reload_q <= '0;
            cnt_q    <= '0;
        end else if (!ctrl_wr) begin
            if (data_wr && (state_q == CH_IDLE || state_q == CH_RUN))
                lo_q <= wdata;
            reload_q <= reload_d;
            if (state_q == CH_LOAD_HI && data_wr)
                cnt_q <= {wdata, lo_q};
            else if (counting)
                cnt_q <= (cnt_q == CNT_W'(1)) ? reload_d : cnt_q - 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            CH_RUN, CH_RUN_HI: tick_n = (cnt_q != CNT_W'(1));
            default:           tick_n = 1'b1;
        endcase
    end

    // R4
    stop_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (state_q == CH_IDLE && tick_n));

    // R5
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE || state_q == CH_LOAD_HI) |-> tick_n);

    // R6
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_LOAD_HI && data_wr && !ctrl_wr)
            |=> (state_q == CH_RUN && cnt_q == $past({wdata, lo_q})));

    // R7
    single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_n && reload_q != CNT_W'(1) && !data_wr && !ctrl_wr) |=> tick_n);

    // R7
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && cnt_q != CNT_W'(1) && !ctrl_wr && !(state_q == CH_LOAD_HI))
            |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
endmodule

// File: rtl/pit_rate_gen.sv
module pit_rate_gen
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [NUM_CH-1:0] chan_out
);
    logic [NUM_CH-1:0] ctrl_hit;
    logic [NUM_CH-1:0] data_hit;

    pit_bus_decode #(.NUM_CH(NUM_CH)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .ctrl_hit (ctrl_hit),
        .data_hit (data_hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pit_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_wr(ctrl_hit[c]),
            .data_wr(data_hit[c]),
            .wdata  (bus_wdata),
            .tick_n (chan_out[c])
        );
    end

    // R1
    reset_high_chk: assert property (@(posedge clk) $rose(rst_n) |-> (chan_out == '1));
endmodule

// File: tb/pit_rate_gen_tb.sv
module pit_rate_gen_tb;
    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [1:0]     bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic [NCH-1:0] chan_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pit_rate_gen #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .chan_out(chan_out)
    );

    // Behavioural reference: per channel running flag, byte-order flag, cycles to pulse
    bit m_act[NCH];
    bit m_ff[NCH];
    int m_lo[NCH];
    int m_rl[NCH];
    int m_ph[NCH];
    logic [NCH-1:0] m_exp;

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            bit started;
            started = 1'b0;
            if (!rst_n) begin
                m_act[c] = 0; m_ff[c] = 0; m_lo[c] = 0; m_rl[c] = 0; m_ph[c] = 0;
            end else begin
                if (bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == c
                    && bus_wdata[5:4] == 2'b11 && bus_wdata[3:1] == 3'b010 && !bus_wdata[0]) begin
                    m_act[c] = 0; m_ff[c] = 0;
                end else if (bus_wr && bus_addr == c) begin
                    if (!m_ff[c]) begin
                        m_lo[c] = bus_wdata; m_ff[c] = 1;
                    end else begin
                        int v;
                        v = bus_wdata * 256 + m_lo[c];
                        if (v == 0) v = 65536;
                        m_ff[c] = 0;
                        m_rl[c] = v;
                        if (!m_act[c]) begin
                            m_act[c] = 1; m_ph[c] = v; started = 1'b1;
                        end
                    end
                end
                if (m_act[c] && !started)
                    m_ph[c] = (m_ph[c] == 1) ? m_rl[c] : m_ph[c] - 1;
            end
            m_exp[c] = !(m_act[c] && m_ph[c] == 1);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (chan_out !== m_exp) begin
                bad++;
                $display("FAIL R7 model compare: actual=%b expected=%b", chan_out, m_exp);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic load(input int ch, input logic [7:0] cw, input int n);
        wr(2'd3, cw);
        wr(2'(ch), 8'(n));
        wr(2'(ch), 8'(n >> 8));
    endtask

    task automatic to_low(input int ch, output int n);
        n = 0;
        while (chan_out[ch] && n < 70000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic period(input int ch, output int n, output int width);
        int d;
        to_low(ch, d);
        @(negedge clk);
        width = chan_out[ch] ? 1 : 2;
        n = 1;
        while (chan_out[ch] && n < 70000) begin
            @(negedge clk); n++;
        end
    endtask

    initial begin
        int n, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(chan_out == '1, "R1 reset outputs", chan_out, 7);

        // R5: low byte only keeps channel stopped
        wr(2'd3, 8'h34);
        wr(2'd0, 8'd5);
        repeat (10) @(negedge clk);
        check(chan_out[0] == 1'b1, "R5 low byte only", chan_out[0], 1);
        wr(2'd0, 8'd0);
        to_low(0, n);
        check(n == 4, "R6 first pulse ch0 N=5", n, 4);
        period(0, n, w);
        check(n == 5, "R7 period ch0", n, 5);
        check(w == 1, "R7 low width ch0", w, 1);

        // R2 R10: second channel, first channel unaffected
        load(1, 8'h74, 3);
        period(1, n, w);
        check(n == 3, "R2 R10 period ch1", n, 3);
        period(0, n, w);
        check(n == 5, "R10 ch0 unaffected", n, 5);

        // R3: ignored control bytes
        wr(2'd3, 8'hF4);
        period(0, n, w);
        check(n == 5, "R3 channel field 11", n, 5);
        wr(2'd3, 8'h35);
        period(0, n, w);
        check(n == 5, "R3 count type bit", n, 5);
        wr(2'd3, 8'h24);
        period(0, n, w);
        check(n == 5, "R3 access field", n, 5);
        wr(2'd3, 8'h3C);
        period(0, n, w);
        check(n == 5, "R3 mode field", n, 5);

        // R4: accepted control byte stops channel
        wr(2'd3, 8'h34);
        w = 1;
        for (int i = 0; i < 12; i++) begin
            if (!chan_out[0]) w = 0;
            @(negedge clk);
        end
        check(w == 1, "R4 stopped after control", w, 1);
        wr(2'd0, 8'd4);
        wr(2'd0, 8'd0);
        period(0, n, w);
        check(n == 4, "R4 restart period", n, 4);

        // R9: new divisor while running
        wr(2'd1, 8'd7);
        wr(2'd1, 8'd0);
        period(1, n, w);
        period(1, n, w);
        check(n == 7, "R9 new divisor ch1", n, 7);

        // R11: divisor of 1
        load(1, 8'h74, 1);
        w = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (chan_out[1]) w = 0;
        end
        check(w == 1, "R11 divisor one low", w, 1);

        // R6: larger divisor on channel 2
        load(2, 8'hB4, 258);
        to_low(2, n);
        check(n == 257, "R6 first pulse ch2 N=258", n, 257);

        // R8: divisor 0 as 65536
        load(2, 8'hB4, 0);
        to_low(2, n);
        check(n == 65535, "R8 divisor zero", n, 65535);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1'b1;
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule